// File: doc/BRIEF.md
# Shared-Timebase Capture/Compare Array

This block contains one 16-bit up counter that runs freely and serves as a common time base for several identical capture/compare units. Each unit owns one pin. It can either sample the pin and record the time of an edge, or drive the pin from compare and pulse-width logic. The counter moves only on a count tick. A 2-bit select field picks the source of that tick: one of two fixed divisions of the system clock, a one-cycle overflow pulse from a neighbouring timer, or the rising edge of an external count input after it has been synchronised.

Software reaches everything through a small byte-wide register port. That port holds a control register (run bit and tick source), a flag register, the counter bytes, one mode register per unit, and the 16-bit capture/compare value of each unit split into two bytes. Any set flag raises a single interrupt line. Each unit can change its mode at run time, so one pin can move from edge timing to toggled output to PWM without a reset.

Top module: `pca_array`

## Requirements
- R1: After reset the control register, the flag register, the counter and every mode register read zero, and every pin_oe, pin_out bit and irq is low.
- R2: Control register at address 0x00 holds the run bit at bit 0. While run is 0 the counter holds its value. While run is 1 the counter adds one on each selected tick.
- R3: Control bits [2:1] choose the tick: 0 gives one tick every DIV_SLOW clocks, 1 gives one every DIV_FAST clocks, 2 gives one per cycle of tmr_ovf high, and 3 gives one per rising edge of ext_cnt after a two-flop synchroniser.
- R4: The counter is read and written at 0x02 (low byte) and 0x03 (high byte). A tick at 0xFFFF wraps it to 0x0000 and sets the overflow flag at bit 7 of the flag register (0x01).
- R5: The mode register of unit m is at 0x08+m (bits [2:0]). Modes 1, 2 and 3 capture on a rising edge, a falling edge, or both edges of the synchronised pin_in[m]. A capture copies the counter into the unit value register and sets flag bit m.
- R6: In mode 4 (software timer), the unit sets flag bit m when a tick moves the counter to the unit value, and it leaves its pin undriven (pin_oe low).
- R7: In mode 5 (toggle output), pin_oe[m] is high, and a compare match sets flag bit m and inverts pin_out[m].
- R8: In mode 6 (PWM), pin_oe[m] is high. pin_out[m] is low while the counter low byte is below the duty value and high otherwise. The duty value is copied from the unit high byte only when a tick carries the low byte from 0xFF to 0x00.
- R9: Writing the flag register clears each flag whose written bit is 0 and leaves flags whose written bit is 1 unchanged. irq is high while any flag is set.
- R10: In mode 0 (off) a unit ignores pin edges and compare matches: it sets no flag, changes no value register, and drives no pin.
- R11: The value register of unit m is at 0x10+2m (low byte) and 0x11+2m (high byte), and it can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| tmr_ovf | input | 1 | Overflow pulse from a neighbouring timer, synchronous |
| ext_cnt | input | 1 | Asynchronous external count input |
| pin_in | input | NUM_MOD | Per-unit pin sense, asynchronous |
| pin_out | output | NUM_MOD | Per-unit pin drive value |
| pin_oe | output | NUM_MOD | Per-unit pin drive enable |
| irq | output | 1 | OR of all flags |

## Verification
The bench builds the array with five units, DIV_SLOW set to 6 and DIV_FAST set to 2. With those small dividers, a 60-cycle window measures both clock-derived rates exactly, whatever the prescaler phase. Most compare, toggle, PWM and wrap scenarios are paced with single tmr_ovf pulses, so each counter step falls on a known clock. Writing the counter directly to 0xFFFF or to 0x00FF brings the full-width wrap and the PWM duty reload within a few cycles.

// File: rtl/pca_pkg.sv
package pca_pkg;
   typedef enum logic [2:0] {
      MD_OFF      = 3'd0,
      MD_CAP_RISE = 3'd1,
      MD_CAP_FALL = 3'd2,
      MD_CAP_BOTH = 3'd3,
      MD_TIMER    = 3'd4,
      MD_TOGGLE   = 3'd5,
      MD_PWM      = 3'd6
   } pca_mode_e;

   localparam logic [4:0] ADR_CTRL   = 5'h00;
   localparam logic [4:0] ADR_FLAGS  = 5'h01;
   localparam logic [4:0] ADR_CNT_LO = 5'h02;
   localparam logic [4:0] ADR_CNT_HI = 5'h03;
   localparam int         OVF_BIT    = 7;
endpackage

// File: rtl/pca_timebase.sv
module pca_timebase #(
   parameter int CNT_W    = 16,
   parameter int DIV_SLOW = 12,
   parameter int DIV_FAST = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       sel,
   input  logic             tmr_ovf,
   input  logic             ext_cnt,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             adv,
   output logic             lo_wrap,
   output logic             ovf_flag
);
   localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int PW      = $clog2(DIV_MAX) + 1;
   localparam int HW      = CNT_W - 8;
   localparam logic [PW-1:0] LIM_S = PW'(DIV_SLOW - 1);
   localparam logic [PW-1:0] LIM_F = PW'(DIV_FAST - 1);

   initial begin
      assert (DIV_SLOW >= 1 && DIV_FAST >= 1) else $error("divider below one");
      assert (CNT_W > 8 && CNT_W <= 16) else $error("counter width out of range");
   end

   logic [PW-1:0] pre;
   logic [PW-1:0] lim;
   logic          div_sel, div_tick, src_tick, any_wr;
   logic          e_s1, e_s2, e_prev, ext_rise;

   assign div_sel  = ~sel[1];
   assign lim      = sel[0] ? LIM_F : LIM_S;
   assign div_tick = div_sel && (pre >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || !div_sel) pre <= '0;
      else if (pre >= lim)            pre <= '0;
      else                            pre <= pre + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) {e_s1, e_s2, e_prev} <= '0;
      else        {e_s1, e_s2, e_prev} <= {ext_cnt, e_s1, e_s2};
   end
   assign ext_rise = e_s2 & ~e_prev;

   always_comb begin
      case (sel)
         2'd2:    src_tick = tmr_ovf;
         2'd3:    src_tick = ext_rise;
         default: src_tick = div_tick;
      endcase
   end

   assign any_wr  = wr_lo | wr_hi;
   assign adv     = run & src_tick & ~any_wr;
   assign cnt_nxt = cnt + 1'b1;
   assign lo_wrap = adv && (cnt[7:0] == 8'hFF);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (any_wr) begin
         if (wr_lo) cnt[7:0]       <= wdata;
         if (wr_hi) cnt[CNT_W-1:8] <= wdata[HW-1:0];
      end
      else if (adv) cnt <= cnt_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    ovf_flag <= 1'b0;
      else if (adv && (cnt == '1))   ovf_flag <= 1'b1;
      else if (ovf_clr)              ovf_flag <= 1'b0;
   end

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !any_wr) |=> $stable(cnt)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt == $past(cnt) + 1'b1)); // R2
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cnt == '1) |=> (ovf_flag && cnt == '0)); // R4
endmodule

// File: rtl/pca_unit.sv
module pca_unit
   import pca_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pca_mode_e        mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             adv,
   input  logic             lo_wrap,
   input  logic             pin_in,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] val,
   output logic             flag,
   output logic             pin_out,
   output logic             pin_oe
);
   localparam int HW = CNT_W - 8;

   logic s1, s2, sp, rise, fall, cap_evt, match, cmp_mode, tog_q;
   logic [7:0] duty;

   always_ff @(posedge clk) begin
      if (!rst_n) {s1, s2, sp} <= '0;
      else        {s1, s2, sp} <= {pin_in, s1, s2};
   end
   assign rise = s2 & ~sp;
   assign fall = ~s2 & sp;

   always_comb begin
      case (mode)
         MD_CAP_RISE: cap_evt = rise;
         MD_CAP_FALL: cap_evt = fall;
         MD_CAP_BOTH: cap_evt = rise | fall;
         default:     cap_evt = 1'b0;
      endcase
   end

   assign cmp_mode = (mode == MD_TIMER) || (mode == MD_TOGGLE);
   assign match    = cmp_mode && adv && (cnt_nxt == val);

   always_ff @(posedge clk) begin
      if (!rst_n) val <= '0;
      else if (cap_evt) val <= cnt;
      else begin
         if (wr_lo) val[7:0]       <= wdata;
         if (wr_hi) val[CNT_W-1:8] <= wdata[HW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                flag <= 1'b0;
      else if (cap_evt || match) flag <= 1'b1;
      else if (flag_clr)         flag <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                             tog_q <= 1'b0;
      else if (match && mode == MD_TOGGLE)    tog_q <= ~tog_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       duty <= '0;
      else if (lo_wrap) duty <= 8'(val[CNT_W-1:8]);
   end

   always_comb begin
      case (mode)
         MD_PWM:    begin pin_out = (cnt[7:0] >= duty); pin_oe = 1'b1; end
         MD_TOGGLE: begin pin_out = tog_q;              pin_oe = 1'b1; end
         default:   begin pin_out = 1'b0;               pin_oe = 1'b0; end
      endcase
   end

   AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (val == $past(cnt) && flag)); // R5
   AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (match && mode == MD_TOGGLE) ##1 (mode == MD_TOGGLE) |-> (pin_out != $past(pin_out))); // R7
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_OFF && !flag) |=> (!flag && $stable(val) || $past(wr_lo || wr_hi))); // R10
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_evt && !match) |=> !flag); // R9
endmodule

// File: rtl/pca_array.sv
module pca_array
   import pca_pkg::*;
#(
   parameter int NUM_MOD  = 5,
   parameter int CNT_W    = 16,
   parameter int DIV_SLOW = 12,
   parameter int DIV_FAST = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         bus_addr,
   input  logic               bus_wr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic               tmr_ovf,
   input  logic               ext_cnt,
   input  logic [NUM_MOD-1:0] pin_in,
   output logic [NUM_MOD-1:0] pin_out,
   output logic [NUM_MOD-1:0] pin_oe,
   output logic               irq
);
   if (NUM_MOD < 1 || NUM_MOD > 7) begin : g_bad_count
      $error("NUM_MOD must lie in 1..7");
   end

   logic             run;
   logic [1:0]       sel;
   pca_mode_e        mode_q [NUM_MOD];
   logic [CNT_W-1:0] val    [NUM_MOD];
   logic [NUM_MOD-1:0] flags;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             adv, lo_wrap, ovf_flag, flag_wr;

   assign flag_wr = bus_wr && (bus_addr == ADR_FLAGS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         sel <= 2'd0;
      end
      else if (bus_wr && bus_addr == ADR_CTRL) begin
         run <= bus_wdata[0];
         sel <= bus_wdata[2:1];
      end
   end

   pca_timebase #(.CNT_W(CNT_W), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .sel     (sel),
      .tmr_ovf (tmr_ovf),
      .ext_cnt (ext_cnt),
      .wr_lo   (bus_wr && bus_addr == ADR_CNT_LO),
      .wr_hi   (bus_wr && bus_addr == ADR_CNT_HI),
      .wdata   (bus_wdata),
      .ovf_clr (flag_wr && !bus_wdata[OVF_BIT]),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .adv     (adv),
      .lo_wrap (lo_wrap),
      .ovf_flag(ovf_flag)
   );

   for (genvar m = 0; m < NUM_MOD; m++) begin : g_unit
      logic mode_hit, val_hit;
      assign mode_hit = bus_wr && bus_addr[4:3] == 2'b01 && bus_addr[2:0] == 3'(m);
      assign val_hit  = bus_wr && bus_addr[4] && bus_addr[3:1] == 3'(m);

      always_ff @(posedge clk) begin
         if (!rst_n)        mode_q[m] <= MD_OFF;
         else if (mode_hit) mode_q[m] <= pca_mode_e'(bus_wdata[2:0]);
      end

      pca_unit #(.CNT_W(CNT_W)) u_unit (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (mode_q[m]),
         .cnt     (cnt),
         .cnt_nxt (cnt_nxt),
         .adv     (adv),
         .lo_wrap (lo_wrap),
         .pin_in  (pin_in[m]),
         .wr_lo   (val_hit && !bus_addr[0]),
         .wr_hi   (val_hit &&  bus_addr[0]),
         .wdata   (bus_wdata),
         .flag_clr(flag_wr && !bus_wdata[m]),
         .val     (val[m]),
         .flag    (flags[m]),
         .pin_out (pin_out[m]),
         .pin_oe  (pin_oe[m])
      );
   end

   assign irq = ovf_flag | (|flags);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADR_CTRL) bus_rdata = {5'b0, sel, run};
      else if (bus_addr == ADR_FLAGS) begin
         for (int m = 0; m < NUM_MOD; m++) bus_rdata[m] = flags[m];
         bus_rdata[OVF_BIT] = ovf_flag;
      end
      else if (bus_addr == ADR_CNT_LO) bus_rdata = cnt[7:0];
      else if (bus_addr == ADR_CNT_HI) bus_rdata = 8'(cnt >> 8);
      else if (bus_addr[4:3] == 2'b01) begin
         for (int m = 0; m < NUM_MOD; m++)
            if (bus_addr[2:0] == 3'(m)) bus_rdata = {5'b0, mode_q[m]};
      end
      else if (bus_addr[4]) begin
         for (int m = 0; m < NUM_MOD; m++)
            if (bus_addr[3:1] == 3'(m))
               bus_rdata = bus_addr[0] ? 8'(val[m] >> 8) : val[m][7:0];
      end
   end

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> irq); // R9
endmodule

// File: tb/sim_pca_array.sv
module sim_pca_array;
   localparam int CLK_PERIOD = 10;
   localparam int NM = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          tmr_ovf = 1'b0;
   logic          ext_cnt = 1'b0;
   logic [NM-1:0] pin_in = '0;
   logic [NM-1:0] pin_out, pin_oe;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pca_array #(.NUM_MOD(NM), .CNT_W(16), .DIV_SLOW(6), .DIV_FAST(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
      .ext_cnt(ext_cnt), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output int d);
      bus_addr = a;
      #1 d = int'(bus_rdata);
   endtask

   task automatic rd16(input logic [4:0] a, output int d);
      int lo, hi;
      rd(a, lo);
      rd(a + 5'd1, hi);
      d = (hi << 8) | lo;
   endtask

   task automatic set_cnt(input int v);
      wr(5'h02, 8'(v));
      wr(5'h03, 8'(v >> 8));
   endtask

   task automatic pulse_ovf();
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
   endtask

   task automatic flag_bit(input int b, output int v);
      int f;
      rd(5'h01, f);
      v = (f >> b) & 1;
   endtask

   task automatic t_reset();
      int v;
      rd(5'h00, v); chk("R1 ctrl", v, 0);
      rd(5'h01, v); chk("R1 flags", v, 0);
      rd16(5'h02, v); chk("R1 counter", v, 0);
      rd(5'h08, v); chk("R1 mode0", v, 0);
      chk("R1 pin_oe", int'(pin_oe), 0);
      chk("R1 pin_out", int'(pin_out), 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_run_gate();
      int a, b;
      wr(5'h00, 8'h02);
      repeat (20) @(negedge clk);
      rd16(5'h02, a); chk("R2 stopped", a, 0);
      wr(5'h00, 8'h03);
      rd16(5'h02, a);
      repeat (40) @(negedge clk);
      rd16(5'h02, b); chk("R2 running fast", b - a, 20);
      wr(5'h00, 8'h02);
      rd16(5'h02, a);
      repeat (20) @(negedge clk);
      rd16(5'h02, b); chk("R2 hold after stop", b, a);
   endtask

   task automatic t_sources();
      int a, b;
      wr(5'h00, 8'h01);
      rd16(5'h02, a);
      repeat (60) @(negedge clk);
      rd16(5'h02, b); chk("R3 slow division", b - a, 10);
      wr(5'h00, 8'h05);
      rd16(5'h02, a);
      for (int i = 0; i < 7; i++) pulse_ovf();
      repeat (2) @(negedge clk);
      rd16(5'h02, b); chk("R3 timer pulses", b - a, 7);
      wr(5'h00, 8'h07);
      rd16(5'h02, a);
      for (int i = 0; i < 5; i++) begin
         ext_cnt = 1'b1; repeat (2) @(negedge clk);
         ext_cnt = 1'b0; repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      rd16(5'h02, b); chk("R3 external edges", b - a, 5);
   endtask

   task automatic t_wrap();
      int v;
      wr(5'h00, 8'h04);
      wr(5'h01, 8'h00);
      set_cnt(16'hFFFF);
      rd16(5'h02, v); chk("R4 counter readback", v, 16'hFFFF);
      wr(5'h00, 8'h05);
      flag_bit(7, v); chk("R4 no overflow yet", v, 0);
      pulse_ovf();
      rd16(5'h02, v); chk("R4 wrap to zero", v, 0);
      flag_bit(7, v); chk("R4 overflow flag", v, 1);
      chk("R9 irq on overflow", int'(irq), 1);
      wr(5'h01, 8'hFF);
      flag_bit(7, v); chk("R9 write one keeps flag", v, 1);
      wr(5'h01, 8'h7F);
      flag_bit(7, v); chk("R9 write zero clears", v, 0);
      chk("R9 irq low", int'(irq), 0);
   endtask

   task automatic t_capture();
      int v;
      wr(5'h00, 8'h00);
      wr(5'h08, 8'h01);
      wr(5'h09, 8'h02);
      wr(5'h0B, 8'h03);
      set_cnt(16'h1234);
      pin_in[0] = 1'b1; repeat (4) @(negedge clk);
      rd16(5'h10, v); chk("R5 rising capture", v, 16'h1234);
      flag_bit(0, v); chk("R5 rising flag", v, 1);
      pin_in[1] = 1'b1; repeat (4) @(negedge clk);
      flag_bit(1, v); chk("R5 falling mode ignores rise", v, 0);
      set_cnt(16'h0A0B);
      pin_in[1] = 1'b0; repeat (4) @(negedge clk);
      rd16(5'h12, v); chk("R5 falling capture", v, 16'h0A0B);
      flag_bit(1, v); chk("R5 falling flag", v, 1);
      set_cnt(16'h5555);
      pin_in[3] = 1'b1; repeat (4) @(negedge clk);
      rd16(5'h16, v); chk("R5 both rise", v, 16'h5555);
      set_cnt(16'h6666);
      pin_in[3] = 1'b0; repeat (4) @(negedge clk);
      rd16(5'h16, v); chk("R5 both fall", v, 16'h6666);
      wr(5'h01, 8'h00);
   endtask

   task automatic t_timer();
      int v;
      wr(5'h00, 8'h04);
      set_cnt(16'h000E);
      wr(5'h14, 8'h10); wr(5'h15, 8'h00);
      rd16(5'h14, v); chk("R11 value readback", v, 16'h0010);
      wr(5'h0A, 8'h04);
      wr(5'h00, 8'h05);
      pulse_ovf();
      flag_bit(2, v); chk("R6 no match early", v, 0);
      pulse_ovf();
      flag_bit(2, v); chk("R6 match flag", v, 1);
      chk("R6 pin not driven", int'(pin_oe[2]), 0);
      wr(5'h01, 8'h00);
   endtask

   task automatic t_toggle();
      int v;
      wr(5'h18, 8'h12); wr(5'h19, 8'h00);
      wr(5'h0C, 8'h05);
      chk("R7 oe high", int'(pin_oe[4]), 1);
      chk("R7 start low", int'(pin_out[4]), 0);
      pulse_ovf();
      chk("R7 no toggle before match", int'(pin_out[4]), 0);
      pulse_ovf();
      chk("R7 toggle on match", int'(pin_out[4]), 1);
      flag_bit(4, v); chk("R7 flag", v, 1);
      wr(5'h02, 8'h11);
      pulse_ovf();
      chk("R7 toggle back", int'(pin_out[4]), 0);
      wr(5'h01, 8'h00);
   endtask

   task automatic t_pwm();
      wr(5'h00, 8'h04);
      wr(5'h17, 8'h40);
      wr(5'h0B, 8'h06);
      set_cnt(16'h00FF);
      chk("R8 oe high", int'(pin_oe[3]), 1);
      chk("R8 old duty zero gives high", int'(pin_out[3]), 1);
      wr(5'h00, 8'h05);
      pulse_ovf();
      chk("R8 reload then low", int'(pin_out[3]), 0);
      wr(5'h02, 8'h40);
      chk("R8 at duty high", int'(pin_out[3]), 1);
      wr(5'h02, 8'h3F);
      chk("R8 below duty low", int'(pin_out[3]), 0);
      wr(5'h17, 8'h10);
      wr(5'h02, 8'h20);
      chk("R8 no reload mid period", int'(pin_out[3]), 0);
   endtask

   task automatic t_off();
      int v;
      wr(5'h01, 8'h00);
      wr(5'h0C, 8'h00);
      chk("R10 pin released", int'(pin_oe[4]), 0);
      pin_in[4] = 1'b1; repeat (4) @(negedge clk);
      pin_in[4] = 1'b0; repeat (4) @(negedge clk);
      set_cnt(16'h0011);
      pulse_ovf();
      flag_bit(4, v); chk("R10 no flag", v, 0);
      rd16(5'h18, v); chk("R10 value kept", v, 16'h0012);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run_gate();
      t_sources();
      t_wrap();
      t_capture();
      t_timer();
      t_toggle();
      t_pwm();
      t_off();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule